// File: doc/BRIEF.md
# Indirect-Addressed Serial Management Register Slave

This block is the management slave of one device on a two-wire serial management bus (MDC clock, bidirectional MDIO data line) that uses indirect addressing. It decodes the frames a station manager clocks in on MDIO. An address frame loads a 16-bit address register. A later write frame or read frame then acts on the location that register holds. A read-with-post-increment frame advances the register after its data phase, which lets the manager walk a block of registers without sending a new address frame each time. A small array of 16-bit storage registers sits behind the address register, so the block can be exercised on its own. For read frames the block drives MDIO through a separate output-enable pin. A pad outside the block forms the tri-state driver.

Reset behaviour is fully defined. Any reset clears the address register to zero. Location zero is a null register: it holds nothing, ignores writes and reads back as zero. A manager that forgets the address frame after reset therefore lands on the null register and cannot disturb real storage.

The frame decoder is a state machine clocked by MDC. Its states are:

- **HUNT**: counts consecutive preamble ones and enters START on a 0 once the count has reached the minimum.
- **START**: returns to HUNT if the second start bit is 1, otherwise moves to OPCODE.
- **OPCODE**: takes two bits, then moves to PORT.
- **PORT**: takes five bits, then moves to DEVICE.
- **DEVICE**: takes five bits, latches the address match, then moves to TURN.
- **TURN**: takes two bits, then moves to DATA.
- **DATA**: takes sixteen bits, commits the frame on the last one, then returns to HUNT.

Top module: `mdio_mmd_slave`

## Requirements
- R1: After reset, mdio_oe is low and the address register is zero, so a read frame sent with no prior address frame returns 16 zero bits.
- R2: A frame consists of a 0 bit or idle, at least PRE_MIN ones, a start code 00, a 2-bit opcode, a 5-bit port address, a 5-bit device address, 2 turnaround bits and 16 data bits, all MSB first and sampled on the rising MDC edge. Opcode 00 loads the address register from the data field. Opcode 01 writes the data field to the addressed location. Opcode 11 reads the addressed location.
- R3: A write to location 0 changes no storage, and a read of location 0 returns 0x0000.
- R4: A write frame sent after reset with no address frame leaves every storage location unchanged.
- R5: On a matched read, mdio_oe stays low during the first turnaround bit period. During the second it is high with mdio_out 0. The 16 data bits then follow MSB first, each changing after a rising MDC edge, and mdio_oe falls after the last data bit.
- R6: Opcode 10 reads like opcode 11 and then increments the address register after the data phase, wrapping from 0xFFFF to 0x0000.
- R7: A frame whose port or device address differs from cfg_port or cfg_dev never raises mdio_oe, does not change the address register and writes nothing.
- R8: A start code other than 00 sends the decoder back to preamble hunting with no register side effect.
- R9: A frame with fewer than PRE_MIN preamble ones is ignored. Exactly PRE_MIN ones is accepted.
- R10: Addresses at or above NUM_REGS read as zero, ignore writes and do not alias onto lower locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; MDIO is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Sampled value of the MDIO line |
| cfg_port | input | 5 | Port address this slave answers to |
| cfg_dev | input | 5 | Device address this slave answers to |
| mdio_out | output | 1 | Value driven onto MDIO while mdio_oe is high |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |

## Verification
On every cycle, the assertions check the following. The output enable rises only inside a matched read frame, and the line is first driven with 0. The enable drops only at the end of a data phase. A broken start code always returns the decoder to HUNT. The address register changes only on the final data bit of a matched frame. A storage entry changes only when it is the target of a write strobe. Other behaviour needs the bench's frame sequences to show it: the exact bit-by-bit read waveform, null-register semantics, post-increment with wrap, the preamble length threshold, out-of-range addressing, and the protection against a missing address frame after reset.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    localparam int DATA_W = 16;
    localparam int PHY_W  = 5;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPC,
        ST_PORT,
        ST_DEV,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    localparam logic [1:0] OPC_ADDR  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_RDINC = 2'b10;
    localparam logic [1:0] OPC_READ  = 2'b11;

endpackage

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 16,
    parameter int AW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    // Location 0 is the null register: no storage is built for it.
    logic [DW-1:0] mem_q [1:NUM_REGS-1];

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wr_en && (wr_addr == AW'(i))) begin
                mem_q[i] <= wr_data;
            end
        end

        // An entry only moves when it is the write target (null and out-of-range writes touch nothing)
        assert_entry_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_addr == AW'(i))) |=> $stable(mem_q[i]))
            else $error("entry %0d changed without a write", i);
    end

    always_comb begin
        rd_data = '0;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = mem_q[i];
            end
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slv_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [PHY_W-1:0]  cfg_port,
    input  logic [PHY_W-1:0]  cfg_dev,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] addr_q,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);

    localparam int PC_W = $clog2(PRE_MIN + 1);
    localparam int BC_W = $clog2(DATA_W);
    localparam logic [PC_W-1:0] PRE_LIM = PC_W'(PRE_MIN);
    localparam logic [BC_W-1:0] LAST_DB = BC_W'(DATA_W - 1);
    localparam logic [BC_W-1:0] LAST_PH = BC_W'(PHY_W - 1);

    frame_state_e      state_q, state_d;
    logic [BC_W-1:0]   bit_cnt_q;
    logic [PC_W-1:0]   pre_cnt_q;
    logic [1:0]        opc_q;
    logic [PHY_W-1:0]  port_q;
    logic [PHY_W-1:0]  dev_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic              hit_q;
    logic              pre_full;
    logic              dev_hit;
    logic              last_bit;
    logic              is_read;

    assign pre_full = (pre_cnt_q >= PRE_LIM);
    assign dev_hit  = (port_q == cfg_port) && ({dev_q[PHY_W-2:0], mdio_in} == cfg_dev);
    assign last_bit = (state_q == ST_DATA) && (bit_cnt_q == LAST_DB);
    assign is_read  = opc_q[1];
    assign wr_data  = {rx_sh_q[DATA_W-2:0], mdio_in};
    assign wr_en    = last_bit && hit_q && (opc_q == OPC_WRITE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (!mdio_in && pre_full)  state_d = ST_START;
            ST_START: state_d = mdio_in ? ST_HUNT : ST_OPC;
            ST_OPC:   if (bit_cnt_q == BC_W'(1)) state_d = ST_PORT;
            ST_PORT:  if (bit_cnt_q == LAST_PH)  state_d = ST_DEV;
            ST_DEV:   if (bit_cnt_q == LAST_PH)  state_d = ST_TURN;
            ST_TURN:  if (bit_cnt_q == BC_W'(1)) state_d = ST_DATA;
            ST_DATA:  if (bit_cnt_q == LAST_DB)  state_d = ST_HUNT;
            default:  state_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Field capture, counters and address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            pre_cnt_q <= '0;
            opc_q     <= '0;
            port_q    <= '0;
            dev_q     <= '0;
            rx_sh_q   <= '0;
            hit_q     <= 1'b0;
            addr_q    <= '0;
        end else begin
            bit_cnt_q <= (state_d != state_q) ? '0 : bit_cnt_q + 1'b1;
            if (state_q == ST_HUNT) begin
                if (!mdio_in)      pre_cnt_q <= '0;
                else if (!pre_full) pre_cnt_q <= pre_cnt_q + 1'b1;
            end else if (state_q == ST_START && mdio_in) begin
                pre_cnt_q <= PC_W'(1);
            end else begin
                pre_cnt_q <= '0;
            end
            if (state_q == ST_OPC)  opc_q  <= {opc_q[0], mdio_in};
            if (state_q == ST_PORT) port_q <= {port_q[PHY_W-2:0], mdio_in};
            if (state_q == ST_DEV) begin
                dev_q <= {dev_q[PHY_W-2:0], mdio_in};
                if (bit_cnt_q == LAST_PH) hit_q <= dev_hit;
            end
            if (state_q == ST_DATA) rx_sh_q <= wr_data;
            if (last_bit && hit_q) begin
                if (opc_q == OPC_ADDR)       addr_q <= wr_data;
                else if (opc_q == OPC_RDINC) addr_q <= addr_q + 1'b1;
            end
        end
    end

    // Line driver outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
            tx_sh_q  <= '0;
        end else begin
            unique case (state_q)
                ST_TURN: begin
                    if (hit_q && is_read) begin
                        if (bit_cnt_q == '0) begin
                            mdio_oe  <= 1'b1;
                            mdio_out <= 1'b0;
                        end else begin
                            mdio_out <= rd_data[DATA_W-1];
                            tx_sh_q  <= {rd_data[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_DATA: begin
                    if (mdio_oe) begin
                        if (bit_cnt_q == LAST_DB) begin
                            mdio_oe  <= 1'b0;
                            mdio_out <= 1'b0;
                        end else begin
                            mdio_out <= tx_sh_q[DATA_W-1];
                            tx_sh_q  <= {tx_sh_q[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                default: begin
                    mdio_oe  <= 1'b0;
                    mdio_out <= 1'b0;
                end
            endcase
        end
    end

    // The line is first driven with the turnaround zero
    assert_turn_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out)
        else $error("line driven high at turnaround");

    // Release happens only at the end of a data phase
    assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> ($past(state_q) == ST_DATA))
        else $error("line released outside data phase");

    // The line is driven only for a matched read
    assert_oe_matched_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (hit_q && is_read))
        else $error("line driven for a non-read or unmatched frame");

    // The address register moves only on the last bit of a matched frame
    assert_addr_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> $past(last_bit && hit_q))
        else $error("address register changed outside a matched commit");

    // A second start bit of 1 aborts to hunting
    assert_bad_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && mdio_in) |=> (state_q == ST_HUNT))
        else $error("bad start code not rejected");

endmodule

// File: rtl/mdio_mmd_slave.sv
module mdio_mmd_slave
    import mdio_slv_pkg::*;
#(
    parameter int PRE_MIN  = 32,
    parameter int NUM_REGS = 8
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic             mdio_in,
    input  logic [PHY_W-1:0] cfg_port,
    input  logic [PHY_W-1:0] cfg_dev,
    output logic             mdio_out,
    output logic             mdio_oe
);

    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] wr_data;
    logic              wr_en;

    mdio_frame_fsm #(
        .PRE_MIN (PRE_MIN)
    ) u_fsm (
        .clk      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .cfg_port (cfg_port),
        .cfg_dev  (cfg_dev),
        .rd_data  (rd_data),
        .addr_q   (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DW       (DATA_W),
        .AW       (DATA_W)
    ) u_bank (
        .clk     (mdc),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/mdio_mmd_slave_bench.sv
`timescale 1ns/1ps
module mdio_mmd_slave_bench;

    localparam logic [4:0] MY_PORT = 5'h03;
    localparam logic [4:0] MY_DEV  = 5'h1E;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdio_in = 1'b1;
    logic       mdio_out;
    logic       mdio_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int words_seen = 0;
    bit done = 1'b0;
    logic [15:0] exp_q [$];

    always #2.5 mdc = ~mdc;

    mdio_mmd_slave u_mdio_mmd_slave (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .cfg_port (MY_PORT),
        .cfg_dev  (MY_DEV),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge mdc);
        mdio_in = b;
    endtask

    // Driver: one full frame; matched reads push their expected word to the scoreboard
    task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] da,
                         input logic [15:0] payload, input bit push, input logic [15:0] exp);
        send_bit(1'b0);
        repeat (pre) send_bit(1'b1);
        send_bit(st[1]); send_bit(st[0]);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(da[i]);
        if (push) exp_q.push_back(exp);
        send_bit(op[1] ? 1'b1 : 1'b1);
        #1;
        if (push) chk(mdio_oe == 1'b0, "R5 oe during first turnaround", {31'b0, mdio_oe}, 32'd0);
        send_bit(op[1] ? 1'b1 : 1'b0);
        for (int i = 15; i >= 0; i--) send_bit(op[1] ? 1'b1 : payload[i]);
    endtask

    task automatic addr_f(input logic [15:0] a);
        frame(32, 2'b00, 2'b00, MY_PORT, MY_DEV, a, 1'b0, 16'h0);
    endtask
    task automatic write_f(input logic [15:0] d);
        frame(32, 2'b00, 2'b01, MY_PORT, MY_DEV, d, 1'b0, 16'h0);
    endtask
    task automatic read_f(input logic [1:0] op, input logic [15:0] exp);
        frame(32, 2'b00, op, MY_PORT, MY_DEV, 16'h0, 1'b1, exp);
    endtask

    // Monitor: rebuilds each driven word from the line and compares it with the scoreboard
    initial begin : monitor
        logic prev_oe = 1'b0;
        logic [15:0] word = '0;
        int nbits = 0;
        forever begin
            @(negedge mdc);
            #1;
            if (mdio_oe && !prev_oe) begin
                chk(mdio_out == 1'b0, "R5 turnaround zero", {31'b0, mdio_out}, 32'd0);
                nbits = 0;
                word = '0;
            end else if (mdio_oe) begin
                word = {word[14:0], mdio_out};
                nbits++;
            end else if (prev_oe) begin
                words_seen++;
                chk(nbits == 16, "R5 data bit count", nbits, 32'd16);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected drive", {16'b0, word}, 32'hFFFF_FFFF);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(word == e, "R2/R5 read word", {16'b0, word}, {16'b0, e});
                end
            end
            prev_oe = mdio_oe;
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R2): got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        int seen;
        repeat (4) @(negedge mdc);
        #1;
        chk(mdio_oe == 1'b0, "R1 oe in reset", {31'b0, mdio_oe}, 32'd0);
        rst_n = 1'b1;

        // R1: read with no address frame hits the null location
        read_f(2'b11, 16'h0000);
        // R4: write with no address frame, then sweep every real location
        write_f(16'hBEEF);
        addr_f(16'd1);
        for (int i = 1; i < 8; i++) read_f(2'b10, 16'h0000);   // R4 sweep

        // R2: address then write then read
        addr_f(16'd3); write_f(16'h1234); read_f(2'b11, 16'h1234);
        addr_f(16'd5); write_f(16'hA5C3); read_f(2'b11, 16'hA5C3);
        // R3: null register
        addr_f(16'd0); write_f(16'hFFFF); read_f(2'b11, 16'h0000);

        // R7: mismatched address frame must not move the address (still 0)
        frame(32, 2'b00, 2'b00, MY_PORT, 5'h01, 16'd5, 1'b0, 16'h0);
        read_f(2'b11, 16'h0000);
        // R7: mismatched read must never drive
        addr_f(16'd3);
        seen = words_seen;
        frame(32, 2'b00, 2'b11, 5'h04, MY_DEV, 16'h0, 1'b0, 16'h0);
        send_bit(1'b1); send_bit(1'b1);
        chk(words_seen == seen, "R7 no drive on mismatch", words_seen, seen);
        // R7: mismatched write must not store
        frame(32, 2'b00, 2'b01, 5'h04, MY_DEV, 16'h9999, 1'b0, 16'h0);
        read_f(2'b11, 16'h1234);

        // R8: bad start code
        frame(32, 2'b01, 2'b01, MY_PORT, MY_DEV, 16'h5555, 1'b0, 16'h0);
        read_f(2'b11, 16'h1234);
        // R9: one preamble bit short
        frame(31, 2'b00, 2'b01, MY_PORT, MY_DEV, 16'h4444, 1'b0, 16'h0);
        read_f(2'b11, 16'h1234);

        // R6: post-increment walk 3 -> 4 -> 5
        read_f(2'b10, 16'h1234);
        read_f(2'b10, 16'h0000);
        read_f(2'b11, 16'hA5C3);
        // R6: wrap from 0xFFFF to 0
        addr_f(16'd1); write_f(16'h0B0B);
        addr_f(16'hFFFF);
        read_f(2'b10, 16'h0000);
        read_f(2'b10, 16'h0000);
        read_f(2'b11, 16'h0B0B);

        // R10: out-of-range address, no aliasing onto location 1
        addr_f(16'd9); write_f(16'h7777); read_f(2'b11, 16'h0000);
        addr_f(16'd1); read_f(2'b11, 16'h0B0B);

        repeat (4) send_bit(1'b1);
        chk(exp_q.size() == 0, "R5 all expected reads seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule